// File: doc/BRIEF.md
# Dual-Table Quantizer with Zigzag Reorder

This block quantizes 8x8 blocks of transform coefficients and sends each block out in zigzag scan order. Coefficients arrive one per valid cycle in natural row order, so position `row*8+col` comes `row*8+col` valid cycles after the block's first coefficient. Each coefficient is divided by a step size taken from one of two tables, one for brightness and one for colour difference. The entry is picked by the coefficient's position, and the quotient is rounded to the nearest integer. The division is done as a multiply by a reciprocal that is worked out when a table entry is written.

The quantized values go into one half of a two-bank buffer at their zigzag address. The other half is read out in sequence at the same time. A stream of blocks entering at full rate therefore leaves at full rate, with the lowest-frequency term first and markers on the first and last element of each block. The step tables are loaded through a one-entry-per-cycle write port while no block is in flight.

Top module: `qzz_quant_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid`, `out_first` and `out_last` are 0.
- R2: A coefficient x with step q comes out as sign(x)*floor((|x| + floor(q/2))/q). This is round to nearest, with ties away from zero, symmetric for negative x. The input range is -2048..2047 and the output is 12-bit signed.
- R3: The step for the coefficient at natural position p (p = row*8+col) is the table entry written with `tbl_pos` = p.
- R4: `in_chroma` is sampled with a block's first coefficient only. 0 selects the table written with `tbl_chroma`=0, and 1 selects the other. Changes to `in_chroma` on the other 63 coefficients have no effect on that block.
- R5: Output element k of a block is the quantized coefficient at natural position zz(k). The path zz starts at (0,0), moves to (0,1), then runs down-left and up-right along the anti-diagonals, turning at the block edges, and ends at (7,7).
- R6: Each block gives exactly 64 cycles with `out_valid` high. `out_first` is high only on the first of them and `out_last` only on the 64th.
- R7: Blocks whose coefficients arrive on consecutive cycles without gaps leave on 128 consecutive valid cycles for two blocks. No idle cycle appears between them.
- R8: Writing step value 0 stores 1, so the coefficient at that position passes through unchanged, including -2048.
- R9: Idle cycles between coefficients of a block (`in_valid` low) do not change the values, order or markers of the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A coefficient is present on `in_coef` |
| in_coef | input | 12 | Signed coefficient, natural row order |
| in_chroma | input | 1 | Table class for the block, sampled on its first coefficient |
| tbl_we | input | 1 | Write one step-table entry |
| tbl_chroma | input | 1 | Table written: 0 brightness, 1 colour difference |
| tbl_pos | input | 6 | Natural position of the entry written |
| tbl_step | input | 8 | Unsigned step value; 0 is stored as 1 |
| out_valid | output | 1 | A quantized coefficient is present on `out_coef` |
| out_coef | output | 12 | Signed quantized coefficient, zigzag order |
| out_first | output | 1 | First element of a block |
| out_last | output | 1 | Last element of a block |

## Verification
The hardest case to reach from the ports is the bank hand-off. The reader finishes one bank on the same cycle that the writer completes the other, and any slip in the full flags shows up as a gap or a repeated block. The stimulus feeds two blocks on 128 consecutive cycles and checks that the output valids are contiguous. Exact rounding ties are also hard to reach with ordinary data. Those are produced by building coefficients of the form ±(n*q + q/2) from the bench's own copy of the even step values.

// File: rtl/qzz_pkg.sv
package qzz_pkg;
  // Scan index of the coefficient at natural position nat in a dim x dim block
  function automatic int zz_scan_index(input int nat, input int dim);
    int r, c, s, base, rlo, rhi;
    r = nat / dim;
    c = nat % dim;
    s = r + c;
    base = 0;
    for (int d = 0; d < 2 * dim - 1; d++) begin
      if (d < s) base += (d < dim) ? d + 1 : 2 * dim - 1 - d;
    end
    rlo = (s > dim - 1) ? s - dim + 1 : 0;
    rhi = (s < dim - 1) ? s : dim - 1;
    // odd diagonals run with row increasing, even ones with row decreasing
    return (s % 2 == 1) ? base + (r - rlo) : base + (rhi - r);
  endfunction
endpackage

// File: rtl/qzz_step_table.sv
module qzz_step_table #(
  parameter int NC  = 64,
  parameter int QW  = 8,
  parameter int RSH = 20,
  parameter int MW  = RSH + 1
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic                    wr_cls,
  input  logic [$clog2(NC)-1:0]   wr_pos,
  input  logic [QW-1:0]           wr_step,
  input  logic                    rd_cls,
  input  logic [$clog2(NC)-1:0]   rd_pos,
  output logic [QW-1:0]           rd_step,
  output logic [MW-1:0]           rd_recip
);
  localparam int AW = $clog2(NC);

  logic [QW-1:0] step_mem  [2*NC];
  logic [MW-1:0] recip_mem [2*NC];

  logic [QW-1:0] step_fix;
  logic [MW-1:0] recip_new;

  // zero is not a legal step; ceil(2^RSH / step) is exact for the numerator range used
  always_comb begin
    step_fix  = (wr_step == '0) ? QW'(1) : wr_step;
    recip_new = ((MW'(1) << RSH) + MW'(step_fix) - MW'(1)) / MW'(step_fix);
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      step_mem[{wr_cls, wr_pos}]  <= step_fix;
      recip_mem[{wr_cls, wr_pos}] <= recip_new;
    end
  end

  always_ff @(posedge clk) begin
    rd_step  <= step_mem[{rd_cls, rd_pos}];
    rd_recip <= recip_mem[{rd_cls, rd_pos}];
  end

  logic [AW-1:0] unused_aw;
  assign unused_aw = '0;
endmodule

// File: rtl/qzz_divider.sv
module qzz_divider #(
  parameter int CW  = 12,
  parameter int QW  = 8,
  parameter int RSH = CW + QW,
  parameter int MW  = RSH + 1
) (
  input  logic signed [CW-1:0] coef,
  input  logic [QW-1:0]        step,
  input  logic [MW-1:0]        recip,
  output logic signed [CW-1:0] quot
);
  localparam int NW = CW + 1;
  localparam int PW = NW + MW;

  logic          neg;
  logic [NW-1:0] mag, num;
  logic [PW-1:0] prod;
  logic [CW-1:0] qmag;

  always_comb begin
    neg  = coef[CW-1];
    mag  = neg ? NW'(-{coef[CW-1], coef}) : NW'({1'b0, coef});
    num  = mag + NW'(step >> 1);
    prod = PW'(num) * PW'(recip);
    qmag = CW'(prod >> RSH);
    quot = neg ? -$signed(qmag) : $signed(qmag);
  end
endmodule

// File: rtl/qzz_reorder.sv
module qzz_reorder #(
  parameter int DIM = 8,
  parameter int CW  = 12
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [$clog2(DIM*DIM)-1:0]     wr_pos,
  input  logic signed [CW-1:0]           wr_data,
  output logic                           out_valid,
  output logic signed [CW-1:0]           out_data,
  output logic                           out_first,
  output logic                           out_last
);
  localparam int NC = DIM * DIM;
  localparam int AW = $clog2(NC);

  logic [AW-1:0] zz_lut [NC];
  for (genvar g = 0; g < NC; g++) begin : g_zz
    assign zz_lut[g] = AW'(qzz_pkg::zz_scan_index(g, DIM));
  end

  logic signed [CW-1:0] bank_mem [2*NC];

  logic          wbank, rbank, rd_active;
  logic [1:0]    full, full_nx;
  logic [AW-1:0] rcnt;
  logic          wr_last, rd_done;

  assign wr_last = wr_en && (wr_pos == AW'(NC - 1));
  assign rd_done = rd_active && (rcnt == AW'(NC - 1));

  always_ff @(posedge clk) begin
    if (wr_en) bank_mem[{wbank, zz_lut[wr_pos]}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    out_data <= bank_mem[{rbank, rcnt}];
  end

  always_comb begin
    full_nx = full;
    if (rd_done) full_nx[rbank] = 1'b0;
    if (wr_last) full_nx[wbank] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbank     <= 1'b0;
      rbank     <= 1'b0;
      rd_active <= 1'b0;
      rcnt      <= '0;
      full      <= '0;
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      full <= full_nx;
      if (wr_last) wbank <= ~wbank;
      if (rd_active) begin
        if (rd_done) begin
          rcnt      <= '0;
          rbank     <= ~rbank;
          rd_active <= full[~rbank];
        end else begin
          rcnt <= rcnt + AW'(1);
        end
      end else if (full[rbank]) begin
        rd_active <= 1'b1;
        rcnt      <= '0;
      end
      out_valid <= rd_active;
      out_first <= rd_active && (rcnt == '0);
      out_last  <= rd_done;
    end
  end
endmodule

// File: rtl/qzz_quant_top.sv
module qzz_quant_top #(
  parameter int DIM = 8,
  parameter int CW  = 12,
  parameter int QW  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic signed [CW-1:0]         in_coef,
  input  logic                         in_chroma,
  input  logic                         tbl_we,
  input  logic                         tbl_chroma,
  input  logic [$clog2(DIM*DIM)-1:0]   tbl_pos,
  input  logic [QW-1:0]                tbl_step,
  output logic                         out_valid,
  output logic signed [CW-1:0]         out_coef,
  output logic                         out_first,
  output logic                         out_last
);
  localparam int NC  = DIM * DIM;
  localparam int AW  = $clog2(NC);
  localparam int RSH = CW + QW;
  localparam int MW  = RSH + 1;

  logic [AW-1:0]        pos_cnt, s1_pos;
  logic                 cls_hold, cls_now, s1_valid;
  logic signed [CW-1:0] s1_coef, q_coef;
  logic [QW-1:0]        s1_step;
  logic [MW-1:0]        s1_recip;

  // the class is taken from the block's first coefficient and held for the rest
  assign cls_now = (pos_cnt == '0) ? in_chroma : cls_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_cnt  <= '0;
      cls_hold <= 1'b0;
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        pos_cnt  <= (pos_cnt == AW'(NC - 1)) ? '0 : pos_cnt + AW'(1);
        cls_hold <= cls_now;
      end
    end
  end

  always_ff @(posedge clk) begin
    s1_coef <= in_coef;
    s1_pos  <= pos_cnt;
  end

  qzz_step_table #(.NC(NC), .QW(QW), .RSH(RSH), .MW(MW)) table_i (
    .clk      (clk),
    .wr_en    (tbl_we),
    .wr_cls   (tbl_chroma),
    .wr_pos   (tbl_pos),
    .wr_step  (tbl_step),
    .rd_cls   (cls_now),
    .rd_pos   (pos_cnt),
    .rd_step  (s1_step),
    .rd_recip (s1_recip)
  );

  qzz_divider #(.CW(CW), .QW(QW), .RSH(RSH), .MW(MW)) div_i (
    .coef  (s1_coef),
    .step  (s1_step),
    .recip (s1_recip),
    .quot  (q_coef)
  );

  qzz_reorder #(.DIM(DIM), .CW(CW)) reorder_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (s1_valid),
    .wr_pos    (s1_pos),
    .wr_data   (q_coef),
    .out_valid (out_valid),
    .out_data  (out_coef),
    .out_first (out_first),
    .out_last  (out_last)
  );
endmodule

// File: rtl/qzz_quant_chk.sv
module qzz_quant_chk #(
  parameter int DIM = 8
) (
  input logic clk,
  input logic rst,
  input logic out_valid,
  input logic out_first,
  input logic out_last
);
  localparam int NC = DIM * DIM;
  localparam int CNW = $clog2(NC) + 1;

  logic           rst_d;
  logic [CNW-1:0] seen;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) seen <= '0;
    else if (out_valid) seen <= out_last ? '0 : seen + CNW'(1);
  end

  // R1: outputs idle on the first cycle after reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> !out_valid && !out_first && !out_last);

  // R6: markers only accompany valid data
  a_r6_markers_valid: assert property (@(posedge clk) disable iff (rst)
    (out_first || out_last) |-> out_valid);

  // R6: first marker exactly at the start of a block
  a_r6_first_position: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_first == (seen == '0)));

  // R6: last marker exactly on the 64th element
  a_r6_last_position: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_last == (seen == CNW'(NC - 1))));
endmodule

bind qzz_quant_top qzz_quant_chk #(.DIM(DIM)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_first (out_first),
  .out_last  (out_last)
);

// File: tb/qzz_quant_top_tb_top.sv
module qzz_quant_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_chroma = 1'b0, tbl_we = 1'b0, tbl_chroma = 1'b0;
  logic signed [11:0] in_coef = '0;
  logic [5:0] tbl_pos = '0;
  logic [7:0] tbl_step = '0;
  logic out_valid, out_first, out_last;
  logic signed [11:0] out_coef;

  always #5 clk = ~clk;

  qzz_quant_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_coef(in_coef),
    .in_chroma(in_chroma), .tbl_we(tbl_we), .tbl_chroma(tbl_chroma),
    .tbl_pos(tbl_pos), .tbl_step(tbl_step), .out_valid(out_valid),
    .out_coef(out_coef), .out_first(out_first), .out_last(out_last)
  );

  int checks = 0, errors = 0;
  int tq [2][64];
  int blk [64];
  int blk2 [64];
  int zzb [64];
  int ov [256];
  bit of [256];
  bit ol [256];
  int oc [256];
  int on = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid && on < 256) begin
      ov[on] = int'(out_coef);
      of[on] = out_first;
      ol[on] = out_last;
      oc[on] = cyc;
      on = on + 1;
    end
  end

  function automatic int qref(int x, int q);
    int m, r;
    m = (x < 0) ? -x : x;
    r = (m + q / 2) / q;
    return (x < 0) ? -r : r;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic build_zz();
    int r = 0, c = 0;
    bit up = 1'b1;
    for (int k = 0; k < 64; k++) begin
      zzb[k] = r * 8 + c;
      if (up) begin
        if (c == 7) begin r++; up = 1'b0; end
        else if (r == 0) begin c++; up = 1'b0; end
        else begin r--; c++; end
      end else begin
        if (r == 7) begin c++; up = 1'b1; end
        else if (c == 0) begin r++; up = 1'b1; end
        else begin r++; c--; end
      end
    end
  endtask

  task automatic write_entry(int cls, int p, int v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_chroma = cls[0]; tbl_pos = p[5:0]; tbl_step = v[7:0];
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic load_tables();
    for (int p = 0; p < 64; p++) begin
      tq[0][p] = 1 + ((p * 13) % 40);
      tq[1][p] = 2 + ((p * 7) % 30) * 2;
      write_entry(0, p, tq[0][p]);
      write_entry(1, p, tq[1][p]);
    end
  endtask

  // second == 1 sends blk2, flip toggles in_chroma after the first coefficient
  task automatic send_block(int cls, bit flip, int gap, bit second);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_coef = second ? blk2[k][11:0] : blk[k][11:0];
      in_chroma = (k == 0) ? cls[0] : (flip ? (((k % 2) == 1) ? ~cls[0] : cls[0]) : cls[0]);
      if (gap > 0 && (k % 3) == 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_out(int n);
    for (int i = 0; i < 400 && on < n; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_block(int base, int cls, string req, bit second);
    int exp;
    for (int k = 0; k < 64; k++) begin
      exp = qref(second ? blk2[zzb[k]] : blk[zzb[k]], tq[cls][zzb[k]]);
      check(req, ov[base + k], exp);
      check("R6 first marker", int'(of[base + k]), (k == 0) ? 1 : 0);
      check("R6 last marker", int'(ol[base + k]), (k == 63) ? 1 : 0);
    end
  endtask

  task automatic t_reset();
    check("R1 valid during reset", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", int'(out_valid), 0);
    check("R1 first after reset", int'(out_first), 0);
    check("R1 last after reset", int'(out_last), 0);
  endtask

  task automatic t_luma_mix();
    for (int p = 0; p < 64; p++) blk[p] = ((p * 97) % 801) - 400;
    blk[0] = 2047; blk[63] = -2048;
    on = 0;
    send_block(0, 1'b0, 0, 1'b0);
    wait_out(64);
    check("R6 count luma", on, 64);
    expect_block(0, 0, "R2 R3 R5 luma value", 1'b0);
  endtask

  task automatic t_ties();
    for (int p = 0; p < 64; p++) begin
      blk[p] = tq[1][p] * (p % 5) + tq[1][p] / 2;
      if (p % 2 == 1) blk[p] = -blk[p];
    end
    on = 0;
    send_block(1, 1'b0, 0, 1'b0);
    wait_out(64);
    check("R6 count ties", on, 64);
    // all chroma steps are even, so every value sits on a half-way point
    expect_block(0, 1, "R2 tie rounding", 1'b0);
  endtask

  task automatic t_class_hold();
    for (int p = 0; p < 64; p++) blk[p] = 600 - p * 19;
    on = 0;
    send_block(1, 1'b1, 0, 1'b0);
    wait_out(64);
    expect_block(0, 1, "R4 chroma held", 1'b0);
    on = 0;
    send_block(0, 1'b1, 0, 1'b0);
    wait_out(64);
    expect_block(0, 0, "R4 luma held", 1'b0);
  endtask

  task automatic t_gaps();
    for (int p = 0; p < 64; p++) blk[p] = (p * 37) % 300 - 150;
    on = 0;
    send_block(0, 1'b0, 2, 1'b0);
    wait_out(64);
    check("R9 count with gaps", on, 64);
    expect_block(0, 0, "R9 value with gaps", 1'b0);
  endtask

  task automatic t_back_to_back();
    for (int p = 0; p < 64; p++) begin
      blk[p] = 1000 - p * 31;
      blk2[p] = (p * 53) % 900 - 450;
    end
    on = 0;
    send_block(1, 1'b0, 0, 1'b0);
    // continue without an idle cycle: the last negedge of send_block dropped in_valid,
    // so drive the second block from that same cycle
    for (int k = 0; k < 64; k++) begin
      if (k > 0) @(negedge clk);
      in_valid = 1'b1; in_coef = blk2[k][11:0]; in_chroma = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    wait_out(128);
    check("R7 count two blocks", on, 128);
    check("R7 contiguous output", oc[127] - oc[0], 127);
    expect_block(0, 1, "R7 first block value", 1'b0);
    expect_block(64, 0, "R7 second block value", 1'b1);
  endtask

  task automatic t_zero_step();
    write_entry(0, 5, 0);
    write_entry(0, 6, 0);
    tq[0][5] = 1;
    tq[0][6] = 1;
    for (int p = 0; p < 64; p++) blk[p] = p * 11 - 300;
    blk[5] = -2048;
    blk[6] = 2047;
    on = 0;
    send_block(0, 1'b0, 0, 1'b0);
    wait_out(64);
    for (int k = 0; k < 64; k++) begin
      if (zzb[k] == 5) check("R8 zero step passes -2048", ov[k], -2048);
      if (zzb[k] == 6) check("R8 zero step passes 2047", ov[k], 2047);
    end
    expect_block(0, 0, "R8 block with zero steps", 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    build_zz();
    repeat (3) @(negedge clk);
    t_reset();
    load_tables();
    t_luma_mix();
    t_ties();
    t_class_hold();
    t_gaps();
    t_back_to_back();
    t_zero_step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule